// File: doc/BRIEF.md
# Dual-Access Sticky Event Status with Alert

This block holds a 32-bit status word that gathers chip events for an external management controller. Single-cycle event pulses from inside the chip set sticky bits. The management controller reaches the word through an I2C slave window of four byte addresses, and writes a 1 to any bit it wants to clear. The internal register bus sees the whole word as read-only, with one exception: three software-owned bits, which it can write directly to signal whatever the system needs.

An alert flag tells the management controller that something new has happened. It is raised when a status bit that is selected by an enable mask goes from 0 to 1. It drops when no enabled bit is set any more, or when the controller acknowledges the alert response. The alert response itself is driven only while an alert-enable control is set. The I2C protocol engine, the alert-address matching and the bus decoding are outside the block, so plain strobes stand in for them.

Bit indices below are storage indices, with 31 as the most significant bit. Index 31 is the reset-occurred event. Indices 30 to 28 are the software bits. Indices 21 to 19 are reserved. Indices 15 to 0 are the per-port events, with index n belonging to port n. Every other index is a chip event.

Top module: `sticky_status_alert`

## Requirements
- R1: After a synchronous reset, `status_o` is 0x0000_0000, and `alert_flag_o` and `alert_resp_o` are 0.
- R2: An event bit is every index except 30..28 and 21..19. A 1 on `evt_i[i]` for an event bit sets `status_o[i]` in the cycle after the clock edge that samples it. The bit then stays set until an I2C write-1-to-clear reaches it.
- R3: An I2C write (`i2c_wr_en_i`=1) with byte address `i2c_addr_i` clears, for each 1 in `i2c_wr_data_i`, the matching bit of that byte only. The byte lanes are: address 0 is bits [31:24], 1 is [23:16], 2 is [15:8] and 3 is [7:0]. A 0 in the write data leaves its bit unchanged.
- R4: If `evt_i[i]` is 1 in the same cycle that a write-1-to-clear targets event bit i, the bit stays set.
- R5: A register-bus write (`rb_wr_en_i`=1) loads bits 30..28 from `rb_wr_data_i[30:28]`. It has no effect on any other bit. `evt_i` has no effect on bits 30..28.
- R6: When a register-bus write and an I2C write-1-to-clear hit the same software bit in the same cycle, the register-bus value is stored.
- R7: Bits 21..19 always read 0, whatever events, register-bus writes or I2C writes arrive.
- R8: `i2c_rd_data_o` shows the byte of `status_o` that `i2c_addr_i` selects, using the lane map of R3.
- R9: If any bit of `status_o & alert_mask_i` is 1 when it was 0 in the previous cycle, `alert_flag_o` is 1 in the next cycle. This holds even when an acknowledge is present in the same cycle.
- R10: If `status_o & alert_mask_i` is zero in a cycle, `alert_flag_o` is 0 in the next cycle.
- R11: An `alert_ack_i` pulse with no new masked 0-to-1 change clears `alert_flag_o` in the next cycle. The flag then stays 0 until a new masked 0-to-1 change occurs.
- R12: `alert_resp_o` is 1 exactly when `alert_flag_o` is 1 and `alert_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| rb_wr_en_i | input | 1 | Register-bus write strobe |
| rb_wr_data_i | input | 32 | Register-bus write data (only bits 30..28 are used) |
| i2c_wr_en_i | input | 1 | I2C byte write strobe (write-1-to-clear) |
| i2c_addr_i | input | 2 | I2C byte offset within the four-byte window |
| i2c_wr_data_i | input | 8 | I2C write data, 1 = clear |
| alert_mask_i | input | 32 | Per-bit alert enables |
| alert_en_i | input | 1 | Alert-response enable |
| alert_ack_i | input | 1 | Alert-response acknowledge pulse |
| status_o | output | 32 | Status word, as read from the register bus |
| i2c_rd_data_o | output | 8 | Selected status byte for I2C reads |
| alert_flag_o | output | 1 | Alert flag |
| alert_resp_o | output | 1 | Alert response request |

## Verification
The directed cases aim at the collisions. An event that arrives together with its own clear must keep the bit set; a design that let the clear win would lose the event. A register-bus write that meets an I2C clear on a software bit must store the bus value; a design with the opposite priority would show the bit cleared. An acknowledge that arrives with a fresh masked rise must leave the alert set, and an acknowledge without one must keep the flag low until the next rise; a design that compares levels instead of edges would raise the flag again at once. Further cases cover byte-lane selection, where a wrong shift would clear the wrong byte, and reserved bits that must stay 0. Random traffic with a changing mask covers the alert rises caused by the mask itself.

// File: rtl/sticky_status_pkg.sv
package sticky_status_pkg;
  localparam int STAT_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = STAT_W / BYTE_W;
  localparam int ADDR_W    = $clog2(NUM_BYTES);
  // software-owned bits and reserved bits, storage indices
  localparam logic [STAT_W-1:0] SW_MASK   = 32'h7000_0000;
  localparam logic [STAT_W-1:0] RSVD_MASK = 32'h0038_0000;
  localparam logic [STAT_W-1:0] EVT_MASK  = ~(SW_MASK | RSVD_MASK);
endpackage

// File: rtl/sst_clr_decode.sv
module sst_clr_decode
  import sticky_status_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int BW = BYTE_W,
  localparam int NB = W / BW,
  localparam int AW = $clog2(NB)
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] data_i,
  output logic [W-1:0]  clr_o
);
  // byte lane 0 maps to the most significant byte
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign clr_o[W-1-b*BW -: BW] =
      (wr_en_i && (addr_i == AW'(b))) ? data_i : '0;
  end
endmodule

// File: rtl/sst_bit_array.sv
module sst_bit_array
  import sticky_status_pkg::*;
#(
  parameter int              W    = STAT_W,
  parameter logic [W-1:0]    SWM  = SW_MASK,
  parameter logic [W-1:0]    RSVM = RSVD_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         rb_wr_en_i,
  input  logic [W-1:0] rb_wr_data_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVM[i]) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{evt_i[i], clr_i[i], rb_wr_data_i[i]};
      assign stat_o[i]   = 1'b0;
    end else if (SWM[i]) begin : g_sw
      logic q;
      logic unused_evt;
      assign unused_evt = evt_i[i];
      // register-bus write outranks the external clear
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (rb_wr_en_i) q <= rb_wr_data_i[i];
        else if (clr_i[i])   q <= 1'b0;
      end
      assign stat_o[i] = q;
    end else begin : g_evt
      logic q;
      logic unused_rb;
      assign unused_rb = rb_wr_data_i[i];
      // a live event outranks the clear
      always_ff @(posedge clk) begin
        if (rst)           q <= 1'b0;
        else if (evt_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign stat_o[i] = q;
    end
  end
endmodule

// File: rtl/sst_alert.sv
module sst_alert
  import sticky_status_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  input  logic         ack_i,
  input  logic         en_i,
  output logic         flag_o,
  output logic         resp_o
);
  logic [W-1:0] masked_now, masked_prev;
  logic         new_rise;
  logic         flag_q;

  assign masked_now = stat_i & mask_i;
  assign new_rise   = |(masked_now & ~masked_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      masked_prev <= '0;
      flag_q      <= 1'b0;
    end else begin
      masked_prev <= masked_now;
      if (new_rise)                flag_q <= 1'b1;
      else if (ack_i)              flag_q <= 1'b0;
      else if (masked_now == '0)   flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign resp_o = flag_q & en_i;
endmodule

// File: rtl/sticky_status_alert.sv
module sticky_status_alert
  import sticky_status_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int BW = BYTE_W,
  localparam int NB = W / BW,
  localparam int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  evt_i,
  input  logic          rb_wr_en_i,
  input  logic [W-1:0]  rb_wr_data_i,
  input  logic          i2c_wr_en_i,
  input  logic [AW-1:0] i2c_addr_i,
  input  logic [BW-1:0] i2c_wr_data_i,
  input  logic [W-1:0]  alert_mask_i,
  input  logic          alert_en_i,
  input  logic          alert_ack_i,
  output logic [W-1:0]  status_o,
  output logic [BW-1:0] i2c_rd_data_o,
  output logic          alert_flag_o,
  output logic          alert_resp_o
);
  logic [W-1:0] clr;
  logic [W-1:0] stat;

  sst_clr_decode #(.W(W), .BW(BW)) u_dec (
    .wr_en_i (i2c_wr_en_i),
    .addr_i  (i2c_addr_i),
    .data_i  (i2c_wr_data_i),
    .clr_o   (clr)
  );

  sst_bit_array #(.W(W), .SWM(SW_MASK), .RSVM(RSVD_MASK)) u_bits (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .clr_i        (clr),
    .rb_wr_en_i   (rb_wr_en_i),
    .rb_wr_data_i (rb_wr_data_i),
    .stat_o       (stat)
  );

  sst_alert #(.W(W)) u_alert (
    .clk    (clk),
    .rst    (rst),
    .stat_i (stat),
    .mask_i (alert_mask_i),
    .ack_i  (alert_ack_i),
    .en_i   (alert_en_i),
    .flag_o (alert_flag_o),
    .resp_o (alert_resp_o)
  );

  assign status_o = stat;

  always_comb begin
    i2c_rd_data_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (i2c_addr_i == AW'(b)) i2c_rd_data_o = stat[W-1-b*BW -: BW];
    end
  end
endmodule

// File: rtl/sticky_status_alert_chk.sv
module sticky_status_alert_chk
  import sticky_status_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [STAT_W-1:0] evt_i,
  input logic              rb_wr_en_i,
  input logic [STAT_W-1:0] rb_wr_data_i,
  input logic              i2c_wr_en_i,
  input logic [STAT_W-1:0] alert_mask_i,
  input logic              alert_ack_i,
  input logic [STAT_W-1:0] status_o,
  input logic              alert_flag_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status_o & RSVD_MASK) == '0); // R7

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & EVT_MASK)) |=> ((status_o & $past(evt_i) & EVT_MASK) == ($past(evt_i) & EVT_MASK))); // R2

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !i2c_wr_en_i |=> ((status_o & $past(status_o) & EVT_MASK) == ($past(status_o) & EVT_MASK))); // R2

  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    rb_wr_en_i |=> ((status_o & SW_MASK) == ($past(rb_wr_data_i) & SW_MASK))); // R6

  AST_ALERT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ((status_o & alert_mask_i & ~$past(status_o & alert_mask_i)) != '0) |=> alert_flag_o); // R9

  AST_ALERT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((status_o & alert_mask_i) == '0) |=> !alert_flag_o); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (alert_ack_i && $stable(status_o & alert_mask_i)) |=> !alert_flag_o); // R11
endmodule

bind sticky_status_alert sticky_status_alert_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_i        (evt_i),
  .rb_wr_en_i   (rb_wr_en_i),
  .rb_wr_data_i (rb_wr_data_i),
  .i2c_wr_en_i  (i2c_wr_en_i),
  .alert_mask_i (alert_mask_i),
  .alert_ack_i  (alert_ack_i),
  .status_o     (status_o),
  .alert_flag_o (alert_flag_o)
);

// File: tb/sticky_status_alert_tb_top.sv
module sticky_status_alert_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SWM  = 32'h7000_0000;
  localparam logic [31:0] RSVM = 32'h0038_0000;
  localparam logic [31:0] EVM  = ~(SWM | RSVM);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt = '0;
  logic        rb_we = 1'b0;
  logic [31:0] rb_wd = '0;
  logic        i2c_we = 1'b0;
  logic [1:0]  i2c_addr = '0;
  logic [7:0]  i2c_wd = '0;
  logic [31:0] amask = '0;
  logic        aen = 1'b0;
  logic        ack = 1'b0;
  logic [31:0] status;
  logic [7:0]  rd_byte;
  logic        aflag, aresp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0;
  logic [31:0] m_prev = '0;
  logic        m_alert = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_status_alert dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .rb_wr_en_i(rb_we), .rb_wr_data_i(rb_wd),
    .i2c_wr_en_i(i2c_we), .i2c_addr_i(i2c_addr), .i2c_wr_data_i(i2c_wd),
    .alert_mask_i(amask), .alert_en_i(aen), .alert_ack_i(ack),
    .status_o(status), .i2c_rd_data_o(rd_byte), .alert_flag_o(aflag), .alert_resp_o(aresp)
  );

  function automatic logic [31:0] lane_vec(logic we, logic [1:0] a, logic [7:0] d);
    logic [31:0] v = '0;
    if (we) v = {24'd0, d} << (8 * (3 - int'(a)));
    return v;
  endfunction

  function automatic logic [7:0] pick_byte(logic [31:0] s, logic [1:0] a);
    return 8'(s >> (8 * (3 - int'(a))));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: apply the driven inputs to the model, then compare all outputs
  task automatic step();
    logic [31:0] clr, nstat, masked, rise;
    logic nalert;
    clr    = lane_vec(i2c_we, i2c_addr, i2c_wd);
    nstat  = (((m_stat & ~clr) | evt) & EVM)
           | ((rb_we ? rb_wd : (m_stat & ~clr)) & SWM);
    masked = m_stat & amask;
    rise   = masked & ~m_prev;
    if (rise != 0)        nalert = 1'b1;
    else if (ack)         nalert = 1'b0;
    else if (masked == 0) nalert = 1'b0;
    else                  nalert = m_alert;
    @(negedge clk);
    m_prev  = masked;
    m_stat  = nstat;
    m_alert = nalert;
    chk(status === m_stat, "R2 status", status, m_stat);
    chk(rd_byte === pick_byte(m_stat, i2c_addr), "R8 read byte", 32'(rd_byte), 32'(pick_byte(m_stat, i2c_addr)));
    chk(aflag === m_alert, "R9 alert flag", 32'(aflag), 32'(m_alert));
    chk(aresp === (m_alert & aen), "R12 alert resp", 32'(aresp), 32'(m_alert & aen));
  endtask

  task automatic idle();
    evt = '0; rb_we = 0; i2c_we = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // drive garbage during reset: it must be ignored
    evt = '1; rb_we = 1; rb_wd = '1;
    @(negedge clk);
    idle();
    @(negedge clk);
    rst = 1'b0;
    chk(status === 32'h0, "R1 reset status", status, 32'h0);
    chk(aflag === 1'b0 && aresp === 1'b0, "R1 reset alert", {30'd0, aflag, aresp}, 32'h0);

    // R2: per-port event sets and holds
    evt = 32'h0000_0001; step(); idle();
    step(); step();
    chk(status[0] === 1'b1, "R2 sticky port0", 32'(status[0]), 32'h1);

    // R3: clear via the wrong byte lane leaves bit; right lane clears
    i2c_we = 1; i2c_addr = 2'd0; i2c_wd = 8'hFF; step(); idle();
    chk(status[0] === 1'b1, "R3 other lane", 32'(status[0]), 32'h1);
    evt = 32'h0000_0300; step(); idle();
    i2c_we = 1; i2c_addr = 2'd3; i2c_wd = 8'h01; step(); idle();
    chk(status === 32'h0000_0300, "R3 lane3 clear", status, 32'h0000_0300);
    i2c_we = 1; i2c_addr = 2'd2; i2c_wd = 8'h01; step(); idle();
    chk(status === 32'h0000_0200, "R3 lane2 clear", status, 32'h0000_0200);

    // R4: event and clear in the same cycle
    evt = 32'h0000_0200; i2c_we = 1; i2c_addr = 2'd2; i2c_wd = 8'h02; step(); idle();
    chk(status[9] === 1'b1, "R4 event beats clear", 32'(status[9]), 32'h1);
    i2c_we = 1; i2c_addr = 2'd2; i2c_wd = 8'h02; step(); idle();

    // R5: register bus only touches bits 30..28; events ignored there
    rb_we = 1; rb_wd = 32'hFFFF_FFFF; step(); idle();
    chk(status === 32'h7000_0000, "R5 rb write", status, 32'h7000_0000);
    evt = 32'h7000_0000; i2c_we = 1; i2c_addr = 2'd0; i2c_wd = 8'h20; step(); idle();
    chk(status === 32'h5000_0000, "R5 evt ignored on sw", status, 32'h5000_0000);

    // R6: register-bus write beats I2C clear
    rb_we = 1; rb_wd = 32'h4000_0000; i2c_we = 1; i2c_addr = 2'd0; i2c_wd = 8'h70; step(); idle();
    chk(status === 32'h4000_0000, "R6 rb wins", status, 32'h4000_0000);
    i2c_we = 1; i2c_addr = 2'd0; i2c_wd = 8'h40; step(); idle();

    // R7: reserved bits stay zero
    evt = RSVM; rb_we = 1; rb_wd = RSVM; step(); idle();
    chk((status & RSVM) === 32'h0, "R7 reserved", status, 32'h0);

    // R9/R10/R11/R12: alert behaviour
    amask = 32'h0000_00F0; aen = 1;
    evt = 32'h0000_0010; step(); idle();
    step();
    chk(aflag === 1'b1 && aresp === 1'b1, "R9 alert raised", {30'd0, aflag, aresp}, 32'h3);
    ack = 1; step(); idle();
    chk(aflag === 1'b0, "R11 ack clears", 32'(aflag), 32'h0);
    step(); step();
    chk(aflag === 1'b0, "R11 no re-raise", 32'(aflag), 32'h0);
    evt = 32'h0000_0020; step(); ack = 1; idle(); ack = 1; step(); idle();
    chk(aflag === 1'b1, "R9 rise beats ack", 32'(aflag), 32'h1);
    aen = 0; step();
    chk(aresp === 1'b0, "R12 resp gated", 32'(aresp), 32'h0);
    i2c_we = 1; i2c_addr = 2'd3; i2c_wd = 8'hF0; step(); idle();
    step();
    chk(aflag === 1'b0, "R10 masked zero clears", 32'(aflag), 32'h0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      evt    = $urandom & $urandom & $urandom & $urandom;
      rb_we  = ($urandom % 8) == 0;
      rb_wd  = $urandom;
      i2c_we = ($urandom % 3) == 0;
      i2c_addr = 2'($urandom);
      i2c_wd = 8'($urandom);
      ack    = ($urandom % 6) == 0;
      aen    = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) amask = $urandom;
      step();
    end
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule